// File: doc/BRIEF.md
# Masked Translation Control Register

This block holds a 64-bit control word for first-stage address translation. The word has two field layouts: a single-range layout and a host layout. A host-mode input picks the layout. The host layout is a superset of the single-range one. It adds fields for a second address range, for two-tag address-space handling, and for a wide-descriptor (128-bit) translation mode. A write takes effect on the clock edge where the write strobe is high. When the protect feature is on, every bit set in the protect word keeps its old contents. The feature is turned on by an enable input, and the protect word arrives with each write.

Two views are produced. The raw view shows the stored contents of the fields that the current layout defines, with every other position at zero. The effective view is what the translation logic uses:

- A higher-level enable forces every field to zero.
- An encryption enable removes the alternate-encryption fields.
- The contiguous-disable fields only act in the wide-descriptor mode.
- That mode forces three fields to one.

A parameter builds the coherence-relaxation field as a fixed zero. All inputs here are plain control pins sampled on the strobe, so the block has no valid/ready stream and no back-pressure.

Top module: `xlat_ctl_reg`

## Requirements
- R1: While reset is active, and on the first cycle after it, `raw_q` and `eff_q` are all zero.
- R2: With `mask_en`=0, a write stores `wr_data` at every position the current layout defines, and `wr_mask` has no effect. `raw_q` shows the new value from the cycle after the strobe edge.
- R3: With `mask_en`=1, a bit whose `wr_mask` bit is 1 keeps its old value and a bit whose `wr_mask` bit is 0 takes `wr_data`.
- R4: In single-range layout (`host_mode`=0), only bits 12, 11, 10, 4, 3, 1 and 0 of `raw_q` can be nonzero.
- R5: In host layout (`host_mode`=1), bits 18 down to 10 and 5 down to 0 are defined, and bits 63:19 and 9:6 read as zero.
- R6: A write leaves unchanged the stored bits that the current layout does not define. Those bits reappear in `raw_q` when the layout switches back. With no strobe, nothing changes.
- R7: With `lvl_en`=0, `eff_q` is all zero, and `raw_q` is not affected.
- R8: With `lvl_en`=1, host layout and stored bit 5 (wide mode) at 1, `eff_q` bits 4, 1 and 0 are 1 whatever is stored there.
- R9: `eff_q` bits 15 and 14 follow the stored bits only in host layout with bit 5 set. Otherwise they are zero.
- R10: With `enc_en`=0, `eff_q` bits 12 and 13 are zero.
- R11: With `FIX_COH`=1, bit 10 is never stored and reads zero in both views. With the default `FIX_COH`=0, bit 10 is an ordinary field.
- R12: Every other defined bit of `eff_q` equals the same bit of `raw_q`. `eff_q` follows `host_mode`, `lvl_en` and `enc_en` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | New register contents |
| wr_mask | input | 64 | Protect word: 1 keeps the old bit |
| mask_en | input | 1 | Enables the protect word |
| lvl_en | input | 1 | Higher-level enable; 0 zeroes the effective view |
| enc_en | input | 1 | Encryption enable for the alternate-encryption fields |
| host_mode | input | 1 | Layout select: 1 host, 0 single-range |
| raw_q | output | 64 | Stored value, limited to the current layout |
| eff_q | output | 64 | Effective value seen by translation |

## Verification
The bench goes after the layout switch. A write made in single-range layout must leave the host-only bits alone. A design that stored the whole word would lose bit 13 when the host layout is selected again. The protect path is checked both with the feature on and with it off. A design that always applied `wr_mask` would fail to store the contiguous-disable bits. A design that never applied it would clear the protected bits 18 to 16 and bit 11. The wide mode is checked with bits 4, 1 and 0 stored as zero, so a missing force shows up as zero. A design that let bits 15 and 14 through without wide mode would show them on `eff_q` after the write that clears bit 5.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

  localparam int REG_W = 64;

  // field positions; consumers decode these
  localparam int B_PROT    = 0;
  localparam int B_INDIR   = 1;
  localparam int B_OVL_USR = 2;
  localparam int B_OVL     = 3;
  localparam int B_ATTR    = 4;
  localparam int B_WIDE    = 5;
  localparam int B_COH     = 10;
  localparam int B_HWAF    = 11;
  localparam int B_ALT0    = 12;
  localparam int B_ALT1    = 13;
  localparam int B_NOCON0  = 14;
  localparam int B_NOCON1  = 15;
  localparam int B_TAG2    = 16;
  localparam int B_NG0     = 17;
  localparam int B_NG1     = 18;

  typedef logic [REG_W-1:0] word_t;

  typedef enum logic {
    LAYOUT_SOLO = 1'b0,
    LAYOUT_HOST = 1'b1
  } layout_e;

  localparam word_t ONE = word_t'(1);

  localparam word_t SOLO_MAP = (ONE << B_ALT0) | (ONE << B_HWAF) | (ONE << B_COH)
                             | (ONE << B_ATTR) | (ONE << B_OVL)  | (ONE << B_INDIR)
                             | (ONE << B_PROT);

  localparam word_t HOST_MAP = SOLO_MAP
                             | (ONE << B_NG1) | (ONE << B_NG0) | (ONE << B_TAG2)
                             | (ONE << B_NOCON1) | (ONE << B_NOCON0) | (ONE << B_ALT1)
                             | (ONE << B_WIDE) | (ONE << B_OVL_USR);

  function automatic word_t layout_map(layout_e lay);
    return (lay == LAYOUT_HOST) ? HOST_MAP : SOLO_MAP;
  endfunction

endpackage

// File: rtl/xlat_ctl_store.sv
module xlat_ctl_store
  import xlat_ctl_pkg::*;
#(
  parameter bit FIX_COH = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  word_t   wr_data,
  input  word_t   wr_mask,
  input  logic    mask_en,
  input  layout_e layout,
  output word_t   raw_q
);

  localparam word_t STORE_MAP = FIX_COH ? (HOST_MAP & ~(ONE << B_COH)) : HOST_MAP;

  word_t store_q;
  word_t lay_map;
  word_t take;

  always_comb begin
    lay_map = layout_map(layout);
    take    = {REG_W{wr_en}} & lay_map & ~(mask_en ? wr_mask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= ((wr_data & take) | (store_q & ~take)) & STORE_MAP;
  end

  assign raw_q = store_q & lay_map;

  // R3: protected bits do not change on a masked write
  a_r3_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mask_en) |=> (((store_q ^ $past(store_q)) & $past(wr_mask)) == '0));

  // R6: bits outside the current layout survive a write
  a_r6_other_layout_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((store_q ^ $past(store_q)) & ~$past(lay_map)) == '0));

  // R6: no strobe, no change
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_q));

  generate
    if (FIX_COH) begin : g_fix_chk
      // R11: coherence field stays zero after any write
      a_r11_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_COH]) |=> !raw_q[B_COH]);
    end
  endgenerate

endmodule

// File: rtl/xlat_ctl_view.sv
module xlat_ctl_view
  import xlat_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  word_t   raw_q,
  input  layout_e layout,
  input  logic    lvl_en,
  input  logic    enc_en,
  output word_t   eff_q
);

  logic  wide_on;
  word_t v;

  assign wide_on = (layout == LAYOUT_HOST) && raw_q[B_WIDE];

  always_comb begin
    v = raw_q;
    if (!enc_en) begin
      v[B_ALT0] = 1'b0;
      v[B_ALT1] = 1'b0;
    end
    if (wide_on) begin
      v[B_ATTR]  = 1'b1;
      v[B_INDIR] = 1'b1;
      v[B_PROT]  = 1'b1;
    end else begin
      v[B_NOCON0] = 1'b0;
      v[B_NOCON1] = 1'b0;
    end
    if (!lvl_en) v = '0;
  end

  assign eff_q = v;

  a_r7_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_en |-> (eff_q == '0));

  a_r8_wide_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_en && layout == LAYOUT_HOST && raw_q[B_WIDE])
      |-> (eff_q[B_ATTR] && eff_q[B_INDIR] && eff_q[B_PROT]));

  a_r9_nocont_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(layout == LAYOUT_HOST && raw_q[B_WIDE]) |-> (eff_q[B_NOCON1:B_NOCON0] == 2'b00));

  a_r10_enc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_en |-> (eff_q[B_ALT1:B_ALT0] == 2'b00));

endmodule

// File: rtl/xlat_ctl_reg.sv
module xlat_ctl_reg
  import xlat_ctl_pkg::*;
#(
  parameter bit FIX_COH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic [63:0] wr_mask,
  input  logic        mask_en,
  input  logic        lvl_en,
  input  logic        enc_en,
  input  logic        host_mode,
  output logic [63:0] raw_q,
  output logic [63:0] eff_q
);

  layout_e layout;
  word_t   raw_w;
  word_t   eff_w;

  assign layout = layout_e'(host_mode);

  xlat_ctl_store #(.FIX_COH(FIX_COH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .mask_en (mask_en),
    .layout  (layout),
    .raw_q   (raw_w)
  );

  xlat_ctl_view u_view (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_q  (raw_w),
    .layout (layout),
    .lvl_en (lvl_en),
    .enc_en (enc_en),
    .eff_q  (eff_w)
  );

  assign raw_q = raw_w;
  assign eff_q = eff_w;

  // R4, R5: nothing outside the host map is ever visible
  a_r5_host_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~HOST_MAP) == '0);
  a_r4_solo_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |-> ((raw_q & ~SOLO_MAP) == '0));

endmodule

// File: tb/xlat_ctl_reg_bench.sv
module xlat_ctl_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] wr_mask = '0;
  logic        mask_en = 1'b0;
  logic        lvl_en = 1'b1;
  logic        enc_en = 1'b1;
  logic        host_mode = 1'b1;
  logic [63:0] raw_q, eff_q, raw_f, eff_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xlat_ctl_reg u_xlat_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .mask_en(mask_en), .lvl_en(lvl_en), .enc_en(enc_en), .host_mode(host_mode),
    .raw_q(raw_q), .eff_q(eff_q)
  );

  xlat_ctl_reg #(.FIX_COH(1'b1)) u_xlat_ctl_reg_fix (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .mask_en(mask_en), .lvl_en(lvl_en), .enc_en(enc_en), .host_mode(host_mode),
    .raw_q(raw_f), .eff_q(eff_f)
  );

  localparam int N_VEC = 14;
  // control bits: {host, wr, mask_en, lvl, enc}
  localparam logic [4:0] T_CTL [N_VEC] = '{
    5'b11011, 5'b01011, 5'b10011, 5'b11110, 5'b11010, 5'b11011, 5'b11010,
    5'b10011, 5'b10001, 5'b00011, 5'b01111, 5'b01011, 5'b10011, 5'b10010 };
  localparam logic [63:0] T_DATA [N_VEC] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 64'hC020, 64'hC000, 64'h3808,
    64'h0, 64'h0, 64'h0, 64'h0403, 64'hFFFF_0000_0000_0020, 64'h0, 64'h0 };
  localparam logic [63:0] T_MASK [N_VEC] = '{
    64'h0, 64'h0, 64'h0, 64'h7_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,
    64'h0, 64'h0, 64'h0, 64'h0800, 64'h0, 64'h0, 64'h0 };
  localparam logic [63:0] T_RAW [N_VEC] = '{
    64'h7FC3F, 64'h0, 64'h7E024, 64'h70000, 64'hC020, 64'hC000, 64'h3808,
    64'h3808, 64'h3808, 64'h1808, 64'h0C03, 64'h0, 64'h2000, 64'h2000 };
  localparam logic [63:0] T_EFF [N_VEC] = '{
    64'h7FC3F, 64'h0, 64'h7E037, 64'h70000, 64'hC033, 64'h0, 64'h0808,
    64'h3808, 64'h0, 64'h1808, 64'h0C03, 64'h0, 64'h2000, 64'h0 };
  string vtag [N_VEC] = '{
    "R5 R2", "R4 R6", "R6 R8 R9", "R3", "R3 R8 R9", "R9", "R10",
    "R12", "R7", "R4", "R3", "R4", "R6", "R10" };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", raw_q, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 raw after reset", raw_q, 64'h0);
    chk("R1 eff after reset", eff_q, 64'h0);

    for (int i = 0; i < N_VEC; i++) begin
      host_mode = T_CTL[i][4];
      wr_en     = T_CTL[i][3];
      mask_en   = T_CTL[i][2];
      lvl_en    = T_CTL[i][1];
      enc_en    = T_CTL[i][0];
      wr_data   = T_DATA[i];
      wr_mask   = T_MASK[i];
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk($sformatf("%s raw vec %0d", vtag[i], i), raw_q, T_RAW[i]);
      chk($sformatf("%s eff vec %0d", vtag[i], i), eff_q, T_EFF[i]);
    end

    // R11: write all ones in host layout, both builds
    host_mode = 1'b1; lvl_en = 1'b1; enc_en = 1'b1; mask_en = 1'b0;
    wr_data = '1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R11 fixed raw", raw_f, 64'h7F83F);
    chk("R11 fixed eff", eff_f, 64'h7F83F);
    chk("R11 default raw keeps bit10", raw_q, 64'h7FC3F);

    // R7: gate drops eff, raw unchanged
    lvl_en = 1'b0;
    #1;
    chk("R7 eff gated", eff_q, 64'h0);
    chk("R7 raw untouched", raw_q, 64'h7FC3F);
    lvl_en = 1'b1;

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 raw after second reset", raw_q, 64'h0);
    chk("R1 fixed raw after second reset", raw_f, 64'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule